// File: doc/BRIEF.md
# Linked-Row Character DMA Fetcher

This block fills a one-row character buffer for a text display by borrowing the processor bus once per character row. When the video timer signals the first raster slice of a row, the fetcher requests the bus. After the acknowledge arrives it reads a two-byte row pointer from the current DMA address. The pointer gives the 12-bit offset of the row inside the text bank, and its top nibble gives four line-attribute bits. The fetcher then streams one character code per character time into the row buffer. Each code is paired with its 4-bit character attribute, read at the same offset in a second bank.

Rows are chained in memory. The pointer for each row sits directly behind the previous row's character data, so the address left over at the end of a row is where the next pointer is read. Vertical sync reloads the address to the start of the text bank. Once the last row's fetch has begun, further requests are suppressed until vertical sync arrives, so retrace does not waste bus cycles. The bus is held from acknowledge until horizontal sync.

Top module: `lineDmaFetch`

## Requirements
- R1: When `sliceZero` is high at a clock edge while the fetcher is idle and not suppressed, `busReq` is high from the following cycle onward.
- R2: A fetch accepted with `rowIdx` equal to 23 suppresses every later `sliceZero` (`busReq` stays low) until `vsync` is seen; after `vsync` requests are accepted again.
- R3: After the first cycle with `busAck` high, the fetcher reads the low pointer byte at `memAddr` = A, then the high pointer byte at A+1. The next `memAddr` is 0x4000 + {high[3:0], low[7:0]}.
- R4: `lineAttr` takes the high pointer byte's bits 7:4. The bits decode as follows. Bit 3 is `scrollRegion`, bit 2 is `logicalBlank`, and bits 1:0 are the size code: 00 normal, 01 double width, 10 double-height top, 11 double-height bottom. `dblWidth` is high for any nonzero size code, `dblHeight` for codes 10 and 11, and `dblBottom` for code 11 only.
- R5: No buffer write happens while `blank` is high. From the first unblanked cycle after the pointer, each unblanked cycle writes one character, and `memAddr` advances by one per write.
- R6: At most 80 characters are written per row with `wide` = 0, and at most 132 with `wide` = 1. `bufIdx` runs 0, 1, 2 and so on.
- R7: When `blank` rises after streaming has started, writing stops. `memAddr` is left at the row start plus the number of characters written.
- R8: `busReq` stays high after streaming ends and falls in the cycle after `hsync` is seen.
- R9: Reset and `vsync` both set `memAddr` to 0x4000.
- R10: `attrAddr` is `memAddr` + 0x1000. `bufData` is {`attrData`[3:0], `memData`[7:0]}. Attribute bit 0 is blink, bit 1 underline, bit 2 reverse and bit 3 bold.
- R11: Once acknowledged, a fetch runs to completion even if `busAck` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-time clock |
| rstN | input | 1 | Active-low synchronous reset |
| sliceZero | input | 1 | Start of slice 0 of a text row |
| blank | input | 1 | Video blanking from the timer |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| rowIdx | input | 5 | Current text row number |
| wide | input | 1 | 1 selects 132-column mode, 0 selects 80 |
| busAck | input | 1 | Bus grant from the processor |
| busReq | output | 1 | Bus request |
| memAddr | output | 16 | Text-bank read address |
| attrAddr | output | 16 | Attribute-bank read address |
| memData | input | 8 | Text-bank read data (same cycle) |
| attrData | input | 4 | Attribute-bank read data (same cycle) |
| bufWe | output | 1 | Row buffer write strobe |
| bufIdx | output | 8 | Row buffer write index |
| bufData | output | 12 | Row buffer write data, attribute over code |
| lineAttr | output | 4 | Latched line-attribute nibble |
| scrollRegion | output | 1 | Row lies in the scrolling region |
| logicalBlank | output | 1 | Row video suppressed |
| dblWidth | output | 1 | Row drawn at double width |
| dblHeight | output | 1 | Row drawn at double height |
| dblBottom | output | 1 | Row is the lower half of a double-height pair |

## Verification
The assertions rely on a few properties of the inputs. Both RAM banks answer in the same cycle. `vsync` arrives only while the fetcher is idle. `hsync` comes only after blanking has ended a row's streaming. Nothing else moves `memAddr` in the cycle after a buffer write. The stimulus follows these rules by driving whole rows through one task. That task raises blanking before `hsync` and pulses `vsync` only between rows. It places each row pointer exactly at the address the previous row left behind.

// File: rtl/lineDmaPkg.sv
package lineDmaPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PLO,
    ST_PHI,
    ST_STREAM,
    ST_DONE
  } fetchState_t;

  typedef struct packed {
    logic reloadBase;
    logic incAddr;
    logic takeLo;
    logic takeHi;
    logic clrIdx;
    logic write;
  } pathCtl_t;
endpackage

// File: rtl/lineDmaCtrl.sv
module lineDmaCtrl
  import lineDmaPkg::*;
#(
  parameter int ROW_W    = 5,
  parameter int LAST_ROW = 23
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sliceZero,
  input  logic             blank,
  input  logic             hsync,
  input  logic             vsync,
  input  logic [ROW_W-1:0] rowIdx,
  input  logic             busAck,
  input  logic             rowFull,
  output pathCtl_t         ctl,
  output logic             busReq
);
  fetchState_t state;
  logic started;
  logic lastSeen;
  logic accept;

  assign accept = (state == ST_IDLE) && sliceZero && !lastSeen;
  assign busReq = (state != ST_IDLE);

  always_comb begin
    ctl = '0;
    ctl.reloadBase = vsync;
    unique case (state)
      ST_PLO: begin
        ctl.takeLo  = 1'b1;
        ctl.incAddr = 1'b1;
      end
      ST_PHI: begin
        ctl.takeHi = 1'b1;
        ctl.clrIdx = 1'b1;
      end
      ST_STREAM: begin
        if (!blank && !rowFull) begin
          ctl.write   = 1'b1;
          ctl.incAddr = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      started  <= 1'b0;
      lastSeen <= 1'b0;
    end else begin
      if (vsync) begin
        lastSeen <= 1'b0;
      end else if (accept && (rowIdx == ROW_W'(LAST_ROW))) begin
        lastSeen <= 1'b1;
      end
      unique case (state)
        ST_IDLE:   if (accept) state <= ST_WAIT;
        ST_WAIT:   if (busAck) state <= ST_PLO;
        ST_PLO:    state <= ST_PHI;
        ST_PHI: begin
          state   <= ST_STREAM;
          started <= 1'b0;
        end
        ST_STREAM: begin
          if (!blank) started <= 1'b1;
          if (blank && started) state <= ST_DONE;
        end
        ST_DONE:   if (hsync) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lineDmaPath.sv
module lineDmaPath
  import lineDmaPkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          CODE_W       = 8,
  parameter int          CATTR_W      = 4,
  parameter int          NARROW_CHARS = 80,
  parameter int          WIDE_CHARS   = 132,
  parameter int          IDX_W        = 8,
  parameter logic [15:0] TEXT_BASE    = 16'h4000,
  parameter logic [15:0] ATTR_OFFSET  = 16'h1000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pathCtl_t                   ctl,
  input  logic                       wide,
  input  logic [CODE_W-1:0]          memData,
  input  logic [CATTR_W-1:0]         attrData,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [ADDR_W-1:0]          attrAddr,
  output logic                       bufWe,
  output logic [IDX_W-1:0]           bufIdx,
  output logic [CATTR_W+CODE_W-1:0]  bufData,
  output logic [3:0]                 lineAttr,
  output logic                       scrollRegion,
  output logic                       logicalBlank,
  output logic                       dblWidth,
  output logic                       dblHeight,
  output logic                       dblBottom,
  output logic                       rowFull
);
  localparam int OFFS_W = CODE_W + 4;

  logic [ADDR_W-1:0] dmaAddr;
  logic [CODE_W-1:0] ptrLo;
  logic [3:0]        attrNib;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  rowCap;
  logic [OFFS_W-1:0] rowOffset;

  assign rowCap    = wide ? IDX_W'(WIDE_CHARS) : IDX_W'(NARROW_CHARS);
  assign rowFull   = (idx == rowCap);
  assign rowOffset = {memData[3:0], ptrLo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaAddr <= ADDR_W'(TEXT_BASE);
      ptrLo   <= '0;
      attrNib <= '0;
      idx     <= '0;
    end else begin
      if (ctl.reloadBase) begin
        dmaAddr <= ADDR_W'(TEXT_BASE);
      end else if (ctl.takeHi) begin
        dmaAddr <= ADDR_W'(TEXT_BASE) + ADDR_W'(rowOffset);
      end else if (ctl.incAddr) begin
        dmaAddr <= dmaAddr + 1'b1;
      end
      if (ctl.takeLo) ptrLo <= memData;
      if (ctl.takeHi) attrNib <= memData[CODE_W-1 -: 4];
      if (ctl.clrIdx) begin
        idx <= '0;
      end else if (ctl.write) begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign memAddr  = dmaAddr;
  assign attrAddr = dmaAddr + ADDR_W'(ATTR_OFFSET);
  assign bufWe    = ctl.write;
  assign bufIdx   = idx;
  assign bufData  = {attrData, memData};
  assign lineAttr = attrNib;

  assign scrollRegion = attrNib[3];
  assign logicalBlank = attrNib[2];
  assign dblWidth     = |attrNib[1:0];
  assign dblHeight    = attrNib[1];
  assign dblBottom    = &attrNib[1:0];
endmodule

// File: rtl/lineDmaFetch.sv
module lineDmaFetch
  import lineDmaPkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          CODE_W       = 8,
  parameter int          CATTR_W      = 4,
  parameter int          ROW_W        = 5,
  parameter int          LAST_ROW     = 23,
  parameter int          NARROW_CHARS = 80,
  parameter int          WIDE_CHARS   = 132,
  parameter logic [15:0] TEXT_BASE    = 16'h4000,
  parameter logic [15:0] ATTR_OFFSET  = 16'h1000,
  localparam int         IDX_W        = $clog2(WIDE_CHARS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sliceZero,
  input  logic                      blank,
  input  logic                      hsync,
  input  logic                      vsync,
  input  logic [ROW_W-1:0]          rowIdx,
  input  logic                      wide,
  input  logic                      busAck,
  output logic                      busReq,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [ADDR_W-1:0]         attrAddr,
  input  logic [CODE_W-1:0]         memData,
  input  logic [CATTR_W-1:0]        attrData,
  output logic                      bufWe,
  output logic [IDX_W-1:0]          bufIdx,
  output logic [CATTR_W+CODE_W-1:0] bufData,
  output logic [3:0]                lineAttr,
  output logic                      scrollRegion,
  output logic                      logicalBlank,
  output logic                      dblWidth,
  output logic                      dblHeight,
  output logic                      dblBottom
);
  pathCtl_t ctl;
  logic     rowFull;

  lineDmaCtrl #(
    .ROW_W   (ROW_W),
    .LAST_ROW(LAST_ROW)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sliceZero(sliceZero),
    .blank    (blank),
    .hsync    (hsync),
    .vsync    (vsync),
    .rowIdx   (rowIdx),
    .busAck   (busAck),
    .rowFull  (rowFull),
    .ctl      (ctl),
    .busReq   (busReq)
  );

  lineDmaPath #(
    .ADDR_W      (ADDR_W),
    .CODE_W      (CODE_W),
    .CATTR_W     (CATTR_W),
    .NARROW_CHARS(NARROW_CHARS),
    .WIDE_CHARS  (WIDE_CHARS),
    .IDX_W       (IDX_W),
    .TEXT_BASE   (TEXT_BASE),
    .ATTR_OFFSET (ATTR_OFFSET)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .wide        (wide),
    .memData     (memData),
    .attrData    (attrData),
    .memAddr     (memAddr),
    .attrAddr    (attrAddr),
    .bufWe       (bufWe),
    .bufIdx      (bufIdx),
    .bufData     (bufData),
    .lineAttr    (lineAttr),
    .scrollRegion(scrollRegion),
    .logicalBlank(logicalBlank),
    .dblWidth    (dblWidth),
    .dblHeight   (dblHeight),
    .dblBottom   (dblBottom),
    .rowFull     (rowFull)
  );
endmodule

// File: rtl/lineDmaChecker.sv
module lineDmaChecker #(
  parameter int          ADDR_W       = 16,
  parameter int          IDX_W        = 8,
  parameter int          NARROW_CHARS = 80,
  parameter int          WIDE_CHARS   = 132,
  parameter logic [15:0] TEXT_BASE    = 16'h4000
) (
  input logic              clk,
  input logic              rstN,
  input logic              sliceZero,
  input logic              blank,
  input logic              hsync,
  input logic              vsync,
  input logic              wide,
  input logic              busReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              bufWe,
  input logic [IDX_W-1:0]  bufIdx
);
  p_req_after_slice_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(sliceZero));

  p_no_write_blanked_r5: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> !blank);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (bufWe && !vsync) |=> memAddr == $past(memAddr) + 1'b1);

  p_row_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> (bufIdx < (wide ? IDX_W'(WIDE_CHARS) : IDX_W'(NARROW_CHARS))));

  p_idx_seq_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bufWe && $past(bufWe)) |-> bufIdx == $past(bufIdx) + 1'b1);

  p_release_on_hsync_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> $past(hsync));

  p_vsync_base_r9: assert property (@(posedge clk) disable iff (!rstN)
    vsync |=> memAddr == ADDR_W'(TEXT_BASE));

  p_bus_owned_r11: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> busReq);
endmodule

bind lineDmaFetch lineDmaChecker #(
  .ADDR_W      (ADDR_W),
  .IDX_W       (IDX_W),
  .NARROW_CHARS(NARROW_CHARS),
  .WIDE_CHARS  (WIDE_CHARS),
  .TEXT_BASE   (TEXT_BASE)
) uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .sliceZero(sliceZero),
  .blank    (blank),
  .hsync    (hsync),
  .vsync    (vsync),
  .wide     (wide),
  .busReq   (busReq),
  .memAddr  (memAddr),
  .bufWe    (bufWe),
  .bufIdx   (bufIdx)
);

// File: tb/lineDmaFetch_test.sv
`timescale 1ns/1ps
module lineDmaFetch_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sliceZero = 1'b0;
  logic        blank = 1'b1;
  logic        hsync = 1'b0;
  logic        vsync = 1'b0;
  logic [4:0]  rowIdx = '0;
  logic        wide = 1'b0;
  logic        busAck = 1'b0;
  logic        busReq;
  logic [15:0] memAddr;
  logic [15:0] attrAddr;
  logic [7:0]  memData;
  logic [3:0]  attrData;
  logic        bufWe;
  logic [7:0]  bufIdx;
  logic [11:0] bufData;
  logic [3:0]  lineAttr;
  logic        scrollRegion, logicalBlank, dblWidth, dblHeight, dblBottom;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int ptrTab[int];
  int curPtr = 'h4000;

  always #10 clk = ~clk;

  function automatic logic [7:0] codeAt(input logic [15:0] a);
    return a[7:0] ^ 8'h5A ^ {a[11:8], 4'h3};
  endfunction

  function automatic logic [3:0] attrAt(input logic [15:0] a);
    return a[3:0] ^ a[7:4] ^ a[11:8] ^ a[15:12];
  endfunction

  always_comb begin
    if (ptrTab.exists(int'(memAddr))) memData = 8'(ptrTab[int'(memAddr)]);
    else memData = codeAt(memAddr);
    attrData = attrAt(attrAddr);
  end

  lineDmaFetch uut (
    .clk(clk), .rstN(rstN), .sliceZero(sliceZero), .blank(blank),
    .hsync(hsync), .vsync(vsync), .rowIdx(rowIdx), .wide(wide),
    .busAck(busAck), .busReq(busReq), .memAddr(memAddr), .attrAddr(attrAddr),
    .memData(memData), .attrData(attrData), .bufWe(bufWe), .bufIdx(bufIdx),
    .bufData(bufData), .lineAttr(lineAttr), .scrollRegion(scrollRegion),
    .logicalBlank(logicalBlank), .dblWidth(dblWidth), .dblHeight(dblHeight),
    .dblBottom(dblBottom)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doRow(input int rIdx, input bit md, input int ackDly,
                       input int nAct, input logic [3:0] nib, input bit dropAck);
    int ptr = curPtr;
    int start = curPtr + 2;
    int cap = md ? 132 : 80;
    int written = 0;
    logic [15:0] a;
    ptrTab[ptr] = start & 'hFF;
    ptrTab[ptr + 1] = {24'h0, nib, 4'(start >> 8)};
    wide = md;
    rowIdx = 5'(rIdx);
    sliceZero = 1'b1;
    step();
    sliceZero = 1'b0;
    #2 chk(busReq == 1'b1, "R1", "busReq after sliceZero", busReq, 1);
    for (int k = 0; k < ackDly; k++) begin
      step();
      #2 chk(busReq == 1'b1 && bufWe == 1'b0, "R1", "request held waiting", busReq, 1);
    end
    busAck = 1'b1;
    step();
    #2 chk(memAddr == 16'(ptr), "R3", "low pointer address", memAddr, ptr);
    if (dropAck) busAck = 1'b0;
    step();
    #2 chk(memAddr == 16'(ptr + 1), "R3", "high pointer address", memAddr, ptr + 1);
    step();
    #2 chk(memAddr == 16'(start), "R3", "row start address", memAddr, start);
    chk(lineAttr == nib, "R4", "line attribute nibble", lineAttr, nib);
    chk(scrollRegion == nib[3] && logicalBlank == nib[2], "R4", "scroll/blank flags",
        {scrollRegion, logicalBlank}, nib[3:2]);
    chk(dblWidth == (nib[1:0] != 2'b00) && dblHeight == nib[1] &&
        dblBottom == (nib[1:0] == 2'b11), "R4", "size flags",
        {dblWidth, dblHeight, dblBottom},
        {nib[1:0] != 2'b00, nib[1], nib[1:0] == 2'b11});
    for (int k = 0; k < 2; k++) begin
      chk(bufWe == 1'b0, "R5", "no write while blanked", bufWe, 0);
      step();
      #2;
    end
    blank = 1'b0;
    for (int i = 0; i < nAct; i++) begin
      #2;
      a = 16'(start + written);
      if (i < cap) begin
        chk(bufWe == 1'b1, "R5", "write each unblanked cycle", bufWe, 1);
        chk(bufIdx == 8'(i), "R6", "buffer index", bufIdx, i);
        chk(memAddr == a, "R5", "address per character", memAddr, a);
        chk(attrAddr == a + 16'h1000, "R10", "attribute bank address", attrAddr, a + 16'h1000);
        chk(bufData == {attrAt(a + 16'h1000), codeAt(a)}, "R10", "buffer data",
            bufData, {attrAt(a + 16'h1000), codeAt(a)});
        written++;
      end else begin
        chk(bufWe == 1'b0, "R6", "no write past row width", bufWe, 0);
      end
      step();
    end
    blank = 1'b1;
    #2 chk(bufWe == 1'b0, "R7", "write stops on blank", bufWe, 0);
    step();
    #2 chk(memAddr == 16'(start + written), "R7", "address left at next pointer",
           memAddr, start + written);
    chk(busReq == 1'b1, dropAck ? "R11" : "R8", "bus still held before hsync", busReq, 1);
    step();
    hsync = 1'b1;
    step();
    hsync = 1'b0;
    #2 chk(busReq == 1'b0, "R8", "bus released after hsync", busReq, 0);
    busAck = 1'b0;
    curPtr = start + written;
    step();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    #2 chk(busReq == 1'b0 && bufWe == 1'b0, "R1", "reset outputs idle", busReq, 0);
    chk(memAddr == 16'h4000, "R9", "reset address", memAddr, 16'h4000);
    rstN = 1'b1;
    step();
    doRow(0, 1'b0, 2, 80, 4'b1000, 1'b0);
    doRow(1, 1'b1, 0, 132, 4'b0101, 1'b0);
    doRow(2, 1'b0, 1, 85, 4'b0010, 1'b0);
    doRow(3, 1'b1, 3, 10, 4'b0111, 1'b1);
    doRow(23, 1'b0, 0, 40, 4'b0011, 1'b0);
    rowIdx = 5'd23;
    sliceZero = 1'b1;
    step();
    sliceZero = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #2 chk(busReq == 1'b0, "R2", "request suppressed after last row", busReq, 0);
      step();
    end
    rowIdx = 5'd0;
    sliceZero = 1'b1;
    step();
    sliceZero = 1'b0;
    #2 chk(busReq == 1'b0, "R2", "row 0 suppressed before vsync", busReq, 0);
    vsync = 1'b1;
    step();
    vsync = 1'b0;
    #2 chk(memAddr == 16'h4000, "R9", "vsync reload", memAddr, 16'h4000);
    curPtr = 'h4000;
    step();
    doRow(0, 1'b0, 1, 80, 4'b1000, 1'b0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule